// File: doc/BRIEF.md
# Extended Bit-Manipulation ALU

A 64-bit execution unit that performs a set of extra bit-manipulation operations chosen by an opcode input: shift-and-add with the shift on the second operand, signed and unsigned bitfield extraction, leading-one and leading-zero searches, full and word byte reversal, a per-byte zero test, a single-bit test, and rotate right by immediate in 64-bit and 32-bit forms. Instruction decoding and the register file sit outside; the block receives two operand values, two 6-bit immediate fields, the opcode and a request to write the destination.

The result is formed combinationally and captured in one output register stage, so a request presented at one rising clock edge shows up on `result_o` and `wen_o` right after that edge. An extract whose low-bit index lies above its high-bit index is dropped: the write enable stays low.

Opcode encoding on `op_i`: 0 shift-add, 1 signed extract, 2 unsigned extract, 3 leading-zero search (first zero), 4 leading-one search (first one), 5 full byte reverse, 6 word byte reverse, 7 zero-byte test, 8 bit test, 9 rotate right, 10 word rotate right; 11 to 15 are unused.

Top module: `xbm_alu`

## Requirements
- R1: Opcode 0 gives rs1 + (rs2 << n), modulo 2^64, where n = imm_lo_i[1:0]; rs1 is never shifted.
- R2: Opcodes 1 and 2 give bits imm_hi_i down to imm_lo_i of rs1, right-justified; opcode 1 fills the upper bits with bit imm_hi_i of rs1, opcode 2 with zeros.
- R3: For opcodes 1 and 2 with imm_lo_i greater than imm_hi_i, wen_o is 0 in the result cycle even when wen_req_i is 1.
- R4: Opcode 4 returns the number of leading zeros of rs1; opcode 3 returns the number of leading zeros of ~rs1; a value with no set bit counts as 64.
- R5: Opcode 5 reverses the order of all 8 bytes of rs1; opcode 6 reverses the 4 bytes of rs1[31:0] and copies bit 31 of that swapped word into bits 63:32.
- R6: Opcode 7 sets each result byte to 8'hFF when the matching byte of rs1 is zero and to 8'h00 otherwise.
- R7: Opcode 8 places rs1[imm_lo_i] in result bit 0 and clears bits 63:1.
- R8: Opcode 9 rotates rs1 right by imm_lo_i[5:0]; opcode 10 rotates rs1[31:0] right by imm_lo_i[4:0] and sign-extends the 32-bit result from bit 31.
- R9: Result and write enable appear one clock after the inputs are sampled; for opcodes 0 to 10 (outside R3) wen_o equals wen_req_i; opcodes 11 to 15 give wen_o = 0 and result 0.
- R10: While rst_ni is low, result_o is 0 and wen_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wen_req_i | input | 1 | Destination write request |
| op_i | input | 4 | Operation select |
| rs1_i | input | 64 | First operand |
| rs2_i | input | 64 | Second operand (shift-add only) |
| imm_hi_i | input | 6 | Extract high-bit index |
| imm_lo_i | input | 6 | Extract low-bit index, shift, rotate amount or bit index |
| result_o | output | 64 | Registered result |
| wen_o | output | 1 | Registered destination write enable |

## Verification
The hardest case to reach from the ports is the leading-bit search near its limits: random 64-bit words almost always have a set bit in the top few positions, so counts above a handful and the all-zero count of 64 never occur by chance. The stimulus therefore draws operands with a random number of high bits forced to zero or one and adds directed all-zero and all-one words. Zero-byte tests receive operands with random bytes cleared, and extracts run with equal, crossed and extreme index pairs.

// File: rtl/xbm_pkg.sv
package xbm_pkg;
  localparam int unsigned XLEN = 64;
  localparam int unsigned WLEN = 32;
  localparam int unsigned IDXW = $clog2(XLEN);
  localparam int unsigned CNTW = IDXW + 1;
  localparam int unsigned NBYTE = XLEN / 8;

  typedef enum logic [3:0] {
    OP_SHADD  = 4'd0,
    OP_EXTS   = 4'd1,
    OP_EXTU   = 4'd2,
    OP_FZERO  = 4'd3,
    OP_FONE   = 4'd4,
    OP_REV    = 4'd5,
    OP_REVW   = 4'd6,
    OP_ZBYTE  = 4'd7,
    OP_BTST   = 4'd8,
    OP_ROR    = 4'd9,
    OP_RORW   = 4'd10
  } xbm_op_e;
endpackage

// File: rtl/xbm_shift_unit.sv
module xbm_shift_unit
  import xbm_pkg::*;
(
  input  logic [XLEN-1:0] rs1_i,
  input  logic [XLEN-1:0] rs2_i,
  input  logic [1:0]      add_sh_i,
  input  logic [IDXW-1:0] rot_sh_i,
  output logic [XLEN-1:0] shadd_o,
  output logic [XLEN-1:0] ror_o,
  output logic [XLEN-1:0] rorw_o
);
  logic [2*XLEN-1:0] dbl;
  logic [2*WLEN-1:0] dblw;
  logic [WLEN-1:0]   w;

  assign shadd_o = rs1_i + (rs2_i << add_sh_i);
  assign dbl     = {rs1_i, rs1_i} >> rot_sh_i;
  assign ror_o   = dbl[XLEN-1:0];
  assign dblw    = {rs1_i[WLEN-1:0], rs1_i[WLEN-1:0]} >> rot_sh_i[IDXW-2:0];
  assign w       = dblw[WLEN-1:0];
  assign rorw_o  = {{(XLEN-WLEN){w[WLEN-1]}}, w};
endmodule

// File: rtl/xbm_field_unit.sv
module xbm_field_unit
  import xbm_pkg::*;
(
  input  logic [XLEN-1:0] src_i,
  input  logic [IDXW-1:0] hi_i,
  input  logic [IDXW-1:0] lo_i,
  input  logic            sext_i,
  output logic [XLEN-1:0] res_o,
  output logic            crossed_o
);
  logic [IDXW-1:0] up_sh;
  logic [IDXW:0]   dn_sh;
  logic [XLEN-1:0] up;

  // Move field top to bit XLEN-1, then shift back down to bit 0.
  assign up_sh     = IDXW'(XLEN-1) - hi_i;
  assign dn_sh     = {1'b0, up_sh} + {1'b0, lo_i};
  assign up        = src_i << up_sh;
  assign crossed_o = lo_i > hi_i;

  always_comb begin
    if (sext_i) res_o = $signed(up) >>> dn_sh;
    else        res_o = up >> dn_sh;
  end
endmodule

// File: rtl/xbm_count_unit.sv
module xbm_count_unit
  import xbm_pkg::*;
(
  input  logic [XLEN-1:0] src_i,
  input  logic            invert_i,
  output logic [CNTW-1:0] cnt_o
);
  logic [XLEN-1:0] v;
  assign v = invert_i ? ~src_i : src_i;

  // Highest set bit wins; empty input counts as XLEN.
  always_comb begin
    cnt_o = CNTW'(XLEN);
    for (int i = 0; i < XLEN; i++) begin
      if (v[i]) cnt_o = CNTW'(XLEN - 1 - i);
    end
  end
endmodule

// File: rtl/xbm_byte_unit.sv
module xbm_byte_unit
  import xbm_pkg::*;
(
  input  logic [XLEN-1:0] src_i,
  output logic [XLEN-1:0] rev_o,
  output logic [XLEN-1:0] revw_o,
  output logic [XLEN-1:0] zbyte_o
);
  localparam int unsigned WBYTE = WLEN / 8;
  logic [WLEN-1:0] wsw;

  for (genvar b = 0; b < NBYTE; b++) begin : g_byte
    assign rev_o[8*b +: 8]   = src_i[8*(NBYTE-1-b) +: 8];
    assign zbyte_o[8*b +: 8] = {8{~|src_i[8*b +: 8]}};
  end

  for (genvar b = 0; b < WBYTE; b++) begin : g_wbyte
    assign wsw[8*b +: 8] = src_i[8*(WBYTE-1-b) +: 8];
  end

  assign revw_o = {{(XLEN-WLEN){wsw[WLEN-1]}}, wsw};
endmodule

// File: rtl/xbm_alu.sv
module xbm_alu
  import xbm_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wen_req_i,
  input  logic [3:0]      op_i,
  input  logic [63:0]     rs1_i,
  input  logic [63:0]     rs2_i,
  input  logic [5:0]      imm_hi_i,
  input  logic [5:0]      imm_lo_i,
  output logic [63:0]     result_o,
  output logic            wen_o
);
  xbm_op_e         op;
  logic [XLEN-1:0] shadd, ror, rorw, fld, rev, revw, zbyte;
  logic [CNTW-1:0] cnt;
  logic            crossed;
  logic [XLEN-1:0] res_d;
  logic            legal, wen_d;

  assign op = xbm_op_e'(op_i);

  xbm_shift_unit u_shift (
    .rs1_i    (rs1_i),
    .rs2_i    (rs2_i),
    .add_sh_i (imm_lo_i[1:0]),
    .rot_sh_i (imm_lo_i),
    .shadd_o  (shadd),
    .ror_o    (ror),
    .rorw_o   (rorw)
  );

  xbm_field_unit u_field (
    .src_i     (rs1_i),
    .hi_i      (imm_hi_i),
    .lo_i      (imm_lo_i),
    .sext_i    (op == OP_EXTS),
    .res_o     (fld),
    .crossed_o (crossed)
  );

  xbm_count_unit u_count (
    .src_i    (rs1_i),
    .invert_i (op == OP_FZERO),
    .cnt_o    (cnt)
  );

  xbm_byte_unit u_byte (
    .src_i   (rs1_i),
    .rev_o   (rev),
    .revw_o  (revw),
    .zbyte_o (zbyte)
  );

  always_comb begin
    legal = 1'b1;
    res_d = '0;
    unique case (op)
      OP_SHADD:         res_d = shadd;
      OP_EXTS, OP_EXTU: begin
        res_d = fld;
        legal = ~crossed;
      end
      OP_FZERO, OP_FONE: res_d = XLEN'(cnt);
      OP_REV:           res_d = rev;
      OP_REVW:          res_d = revw;
      OP_ZBYTE:         res_d = zbyte;
      OP_BTST:          res_d = XLEN'(rs1_i[imm_lo_i]);
      OP_ROR:           res_d = ror;
      OP_RORW:          res_d = rorw;
      default:          legal = 1'b0;
    endcase
    wen_d = wen_req_i & legal;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      wen_o    <= 1'b0;
    end else begin
      result_o <= res_d;
      wen_o    <= wen_d;
    end
  end
endmodule

// File: rtl/xbm_alu_chk.sv
module xbm_alu_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wen_req_i,
  input logic [3:0]  op_i,
  input logic [5:0]  imm_hi_i,
  input logic [5:0]  imm_lo_i,
  input logic [63:0] result_o,
  input logic        wen_o
);
  p_no_req_no_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wen_req_i |=> !wen_o);

  p_unused_op_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i > 4'd10) |=> (!wen_o && result_o == 64'd0));

  p_crossed_field_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((op_i == 4'd1 || op_i == 4'd2) && imm_lo_i > imm_hi_i) |=> !wen_o);

  p_count_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 4'd3 || op_i == 4'd4) |=> (result_o <= 64'd64));

  p_revw_sext_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 4'd6) |=> (result_o[63:32] == {32{result_o[31]}}));

  p_zbyte_mask_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 4'd7) |=> ((result_o[7:0] == 8'h00 || result_o[7:0] == 8'hFF) &&
                        (result_o[63:56] == 8'h00 || result_o[63:56] == 8'hFF)));

  p_btst_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 4'd8) |=> (result_o[63:1] == 63'd0));

  p_rorw_sext_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 4'd10) |=> (result_o[63:32] == {32{result_o[31]}}));

  always @(posedge clk_i) begin
    if (!rst_ni) a_reset_idle_r10: assert (!wen_o && result_o == 64'd0);
  end
endmodule

bind xbm_alu xbm_alu_chk u_chk (.*);

// File: tb/xbm_alu_test.sv
`timescale 1ns/1ps
module xbm_alu_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wen_req = 1'b0;
  logic [3:0]  op = '0;
  logic [63:0] a = '0, b = '0;
  logic [5:0]  hi = '0, lo = '0;
  logic [63:0] result;
  logic        wen;
  int          errors = 0, checks = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  xbm_alu uut (
    .clk_i(clk), .rst_ni(rst_n), .wen_req_i(wen_req), .op_i(op),
    .rs1_i(a), .rs2_i(b), .imm_hi_i(hi), .imm_lo_i(lo),
    .result_o(result), .wen_o(wen)
  );

  function automatic logic [63:0] m_clz(input logic [63:0] v);
    int n = 0;
    for (int i = 63; i >= 0; i--) begin
      if (v[i]) break;
      n++;
    end
    return 64'(n);
  endfunction

  function automatic string req_of(input logic [3:0] o);
    case (o)
      4'd0: return "R1";
      4'd1, 4'd2: return "R2";
      4'd3, 4'd4: return "R4";
      4'd5, 4'd6: return "R5";
      4'd7: return "R6";
      4'd8: return "R7";
      4'd9, 4'd10: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic model(input logic [3:0] o, input logic [63:0] x, input logic [63:0] y,
                       input logic [5:0] h, input logic [5:0] l, input logic req,
                       output logic [63:0] r, output logic w, output logic rcare);
    logic [31:0] t;
    r = '0; w = req; rcare = 1'b1;
    case (o)
      4'd0: r = x + (y << l[1:0]);
      4'd1, 4'd2: begin
        if (l > h) begin w = 1'b0; rcare = 1'b0; end
        else for (int i = 0; i < 64; i++)
          r[i] = (i <= int'(h) - int'(l)) ? x[int'(l) + i] : ((o == 4'd1) ? x[h] : 1'b0);
      end
      4'd3: r = m_clz(~x);
      4'd4: r = m_clz(x);
      4'd5: for (int i = 0; i < 8; i++) r[8*i +: 8] = x[8*(7-i) +: 8];
      4'd6: begin
        for (int i = 0; i < 4; i++) t[8*i +: 8] = x[8*(3-i) +: 8];
        r = {{32{t[31]}}, t};
      end
      4'd7: for (int i = 0; i < 8; i++) r[8*i +: 8] = (x[8*i +: 8] == 8'h00) ? 8'hFF : 8'h00;
      4'd8: r = {63'd0, x[l]};
      4'd9: for (int i = 0; i < 64; i++) r[i] = x[(i + int'(l)) % 64];
      4'd10: begin
        for (int i = 0; i < 32; i++) t[i] = x[(i + int'(l[4:0])) % 32];
        r = {{32{t[31]}}, t};
      end
      default: w = 1'b0;
    endcase
  endtask

  task automatic run(input logic [3:0] o, input logic [63:0] x, input logic [63:0] y,
                     input logic [5:0] h, input logic [5:0] l, input logic req);
    logic [63:0] er; logic ew, care;
    model(o, x, y, h, l, req, er, ew, care);
    @(negedge clk);
    op = o; a = x; b = y; hi = h; lo = l; wen_req = req;
    @(posedge clk); #1;
    checks++;
    if (wen !== ew || (care && result !== er)) begin
      errors++;
      $display("FAIL %s%s op=%0d wen=%b/%b result=%h expected=%h",
               req_of(o), (o inside {4'd1, 4'd2} && l > h) ? "/R3" : "",
               o, wen, ew, result, er);
    end
  endtask

  function automatic logic [63:0] shaped();
    logic [63:0] v = {$urandom, $urandom};
    int k = $urandom_range(0, 70);
    case ($urandom_range(0, 3))
      0: if (k < 64) v = v >> k; else v = '0;         // leading zeros
      1: if (k < 64) v = ~(~v >> k); else v = '1;     // leading ones
      2: for (int i = 0; i < 8; i++) if ($urandom_range(0, 1)) v[8*i +: 8] = 8'h00;
      default: ;
    endcase
    return v;
  endfunction

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    // R10: reset state
    #7;
    checks++;
    if (result !== 64'd0 || wen !== 1'b0) begin
      errors++;
      $display("FAIL R10 result=%h wen=%b expected=0 0", result, wen);
    end
    @(negedge clk); rst_n = 1'b1;

    // R1: second operand shifted, with carries
    run(4'd0, 64'h1, 64'h3, 6'd0, 6'd3, 1'b1);
    run(4'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0001, 6'd0, 6'd1, 1'b1);
    // R2/R3: extract corners
    run(4'd1, 64'h8000_0000_0000_0000, 64'd0, 6'd63, 6'd63, 1'b1);
    run(4'd2, 64'hF0F0_0000_0000_0000, 64'd0, 6'd63, 6'd0, 1'b1);
    run(4'd1, 64'h0000_0000_0000_00A0, 64'd0, 6'd7, 6'd4, 1'b1);
    run(4'd2, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 6'd4, 6'd5, 1'b1);  // R3
    run(4'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 6'd0, 6'd63, 1'b1); // R3
    // R4: all-zero and all-one inputs
    run(4'd4, 64'd0, 64'd0, 6'd0, 6'd0, 1'b1);
    run(4'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 6'd0, 6'd0, 1'b1);
    run(4'd4, 64'd1, 64'd0, 6'd0, 6'd0, 1'b1);
    run(4'd3, 64'h7FFF_FFFF_FFFF_FFFF, 64'd0, 6'd0, 6'd0, 1'b1);
    // R5
    run(4'd5, 64'h0102_0304_0506_0708, 64'd0, 6'd0, 6'd0, 1'b1);
    run(4'd6, 64'hDEAD_BEEF_0000_0080, 64'd0, 6'd0, 6'd0, 1'b1);
    // R6
    run(4'd7, 64'h00FF_0100_0000_1200, 64'd0, 6'd0, 6'd0, 1'b1);
    // R7
    run(4'd8, 64'h8000_0000_0000_0000, 64'd0, 6'd0, 6'd63, 1'b1);
    // R8
    run(4'd9, 64'h0000_0000_0000_0001, 64'd0, 6'd0, 6'd1, 1'b1);
    run(4'd10, 64'h1234_5678_0000_0001, 64'd0, 6'd0, 6'd33, 1'b1);
    // R9: no request, unused opcodes
    run(4'd0, 64'd5, 64'd5, 6'd0, 6'd1, 1'b0);
    run(4'd13, 64'hFFFF, 64'd0, 6'd0, 6'd0, 1'b1);
    run(4'd15, 64'd0, 64'd0, 6'd0, 6'd0, 1'b1);

    for (int i = 0; i < 3000; i++) begin
      logic [3:0] o = 4'($urandom_range(0, 15));
      logic [5:0] h = 6'($urandom), l = 6'($urandom);
      if (o inside {4'd1, 4'd2} && $urandom_range(0, 3) != 0 && l > h) begin
        logic [5:0] s = h; h = l; l = s;
      end
      run(o, shaped(), {$urandom, $urandom}, h, l, $urandom_range(0, 7) != 0);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule